// File: doc/BRIEF.md
# Floating-Point NaN Classify and Quiet Unit

This unit inspects a single floating-point operand in one of four storage formats (half, bfloat16, single or double) and reports whether it is a NaN and, if so, whether it counts as quiet or signaling. For the same operand it also produces a quieted copy and the default NaN encoding of the selected format. All of these results are registered and appear one clock after an input strobe, together with a valid flag.

The interpretation of NaNs is chosen at run time. A polarity input decides whether a set most significant fraction bit marks a NaN as quiet or as signaling. A second input switches off signaling NaNs completely, so that every NaN is reported as quiet. A style input picks the default NaN layout, since hosts disagree on it. The polarity changes both the quieting rule and the default NaN.

The unit sits next to a floating-point datapath. That datapath uses the flags to decide whether an invalid-operation condition applies, and it uses the quieted value or the default NaN as its result.

Top module: `fpnan_unit`

## Requirements
- R1: While reset is high, and after it until the first strobe, out_valid is 0 and every flag and data output is 0.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high. Without a strobe, every result output keeps its last value.
- R3: Format codes are 0 half (exponent bits 14..10, fraction 9..0), 1 bfloat16 (exponent 14..7, fraction 6..0), 2 single (exponent 30..23, fraction 22..0) and 3 double (exponent 62..52, fraction 51..0). Operand bits above the selected width are ignored. With snan_pol 0, a NaN (all exponent bits ones) whose top fraction bit is 1 is quiet. A NaN whose top fraction bit is 0 and whose lower fraction bits are nonzero is signaling.
- R4: With snan_pol 1 the tests swap: a set top fraction bit marks a signaling NaN, and a clear top fraction bit with nonzero lower fraction bits marks a quiet NaN.
- R5: With nosig_mode 1, every NaN is reported as quiet and out_is_snan stays 0, whatever the polarity.
- R6: Infinities, zeros and finite numbers give 0 on out_is_nan, out_is_qnan and out_is_snan. For a NaN, exactly one of out_is_qnan and out_is_snan is 1.
- R7: out_quiet equals the operand, restricted to the selected width with zeros above, unless the operand is a signaling NaN. With snan_pol 0, a signaling NaN gets its top fraction bit set.
- R8: With snan_pol 1, a signaling NaN is quieted by clearing its top fraction bit and setting the fraction bit directly below it.
- R9: With dnan_style 0 or 3, out_dnan has sign 0, all exponent bits set, and either only the top fraction bit set (snan_pol 0) or every fraction bit except the top one set (snan_pol 1).
- R10: With dnan_style 1, out_dnan has sign 0, all exponent bits set and all fraction bits set, for either polarity.
- R11: With dnan_style 2, out_dnan has sign 1, all exponent bits set and only the top fraction bit set, for either polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: capture results for the current inputs |
| in_fmt | input | 2 | Format code (0 half, 1 bfloat16, 2 single, 3 double) |
| in_operand | input | 64 | Operand, right-aligned |
| snan_pol | input | 1 | 0: set top fraction bit means quiet; 1: it means signaling |
| nosig_mode | input | 1 | 1: signaling NaNs are not recognized |
| dnan_style | input | 2 | Default NaN layout select |
| out_valid | output | 1 | Results valid, one cycle after the strobe |
| out_is_nan | output | 1 | Operand is any NaN |
| out_is_qnan | output | 1 | Operand is a quiet NaN |
| out_is_snan | output | 1 | Operand is a signaling NaN |
| out_quiet | output | 64 | Quieted copy of the operand, zero-extended |
| out_dnan | output | 64 | Default NaN of the selected format, zero-extended |

## Verification
The bench uses NaNs that carry only the top fraction bit and NaNs that carry only the lowest fraction bit. A design that treats any exponent-all-ones value as signaling, or that ignores the nonzero-fraction condition, reports infinity as a NaN or misreports one of these operands. Each format is run under both polarities and in no-signaling mode, so a lane with a misplaced field or an unswapped test shows wrong flags. Quieting is checked on negative and positive signaling NaNs, on quiet NaNs and on finite values, and with garbage above a narrow operand. This shows up a rule applied to the wrong bit, quieting applied to non-signaling inputs, and upper bits leaking into the result. Every default NaN style is checked against each polarity, and a hold check confirms that outputs do not follow the inputs without a strobe.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;

  localparam int NUM_FMT = 4;
  localparam int MAX_W   = 64;
  localparam int FMT_W   = $clog2(NUM_FMT);

  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_BF16   = 2'd1,
    FMT_SINGLE = 2'd2,
    FMT_DOUBLE = 2'd3
  } fp_fmt_e;

  typedef enum logic [1:0] {
    DNAN_BY_POL  = 2'd0,
    DNAN_ALL_ONE = 2'd1,
    DNAN_NEG_TOP = 2'd2,
    DNAN_ALIAS   = 2'd3
  } dnan_style_e;

  function automatic int fmt_exp_w(input int f);
    case (f)
      0:       return 5;
      1:       return 8;
      2:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmt_frac_w(input int f);
    case (f)
      0:       return 10;
      1:       return 7;
      2:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/fpnan_classify_lane.sv
module fpnan_classify_lane #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MAG_W = EXP_W + FRAC_W
) (
  input  logic [MAG_W-1:0] mag_i,
  input  logic             pol_i,
  input  logic             nosig_i,
  output logic             is_nan_o,
  output logic             is_qnan_o,
  output logic             is_snan_o
);

  logic exp_ones;
  logic top_bit;
  logic low_nz;
  logic marked;
  logic unmarked;

  assign exp_ones = &mag_i[FRAC_W +: EXP_W];
  assign top_bit  = mag_i[FRAC_W-1];
  assign low_nz   = |mag_i[FRAC_W-2:0];
  assign marked   = exp_ones & top_bit;
  assign unmarked = exp_ones & ~top_bit & low_nz;

  always_comb begin
    is_nan_o = marked | unmarked;
    if (nosig_i) begin
      is_qnan_o = marked | unmarked;
      is_snan_o = 1'b0;
    end else if (pol_i) begin
      is_qnan_o = unmarked;
      is_snan_o = marked;
    end else begin
      is_qnan_o = marked;
      is_snan_o = unmarked;
    end
  end

endmodule

// File: rtl/fpnan_pattern_lane.sv
module fpnan_pattern_lane #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int TOT_W = 1 + EXP_W + FRAC_W
) (
  input  logic [TOT_W-1:0] op_i,
  input  logic             is_snan_i,
  input  logic             pol_i,
  input  logic [1:0]       style_i,
  output logic [TOT_W-1:0] quiet_o,
  output logic [TOT_W-1:0] dnan_o
);

  import fpnan_pkg::*;

  always_comb begin
    quiet_o = op_i;
    if (is_snan_i) begin
      if (pol_i) begin
        quiet_o[FRAC_W-1] = 1'b0;
        quiet_o[FRAC_W-2] = 1'b1;
      end else begin
        quiet_o[FRAC_W-1] = 1'b1;
      end
    end
  end

  always_comb begin
    dnan_o = '0;
    dnan_o[FRAC_W +: EXP_W] = '1;
    case (dnan_style_e'(style_i))
      DNAN_ALL_ONE: dnan_o[FRAC_W-1:0] = '1;
      DNAN_NEG_TOP: begin
        dnan_o[TOT_W-1]  = 1'b1;
        dnan_o[FRAC_W-1] = 1'b1;
      end
      default: begin
        if (pol_i) dnan_o[FRAC_W-2:0] = '1;
        else       dnan_o[FRAC_W-1]   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/fpnan_unit.sv
module fpnan_unit
  import fpnan_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_fmt,
  input  logic [63:0]      in_operand,
  input  logic             snan_pol,
  input  logic             nosig_mode,
  input  logic [1:0]       dnan_style,
  output logic             out_valid,
  output logic             out_is_nan,
  output logic             out_is_qnan,
  output logic             out_is_snan,
  output logic [63:0]      out_quiet,
  output logic [63:0]      out_dnan
);

  logic [NUM_FMT-1:0] lane_nan;
  logic [NUM_FMT-1:0] lane_qnan;
  logic [NUM_FMT-1:0] lane_snan;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_lane
    localparam int EW = fmt_exp_w(g);
    localparam int FW = fmt_frac_w(g);
    localparam int TW = 1 + EW + FW;

    logic [TW-1:0]    quiet_n;
    logic [TW-1:0]    dnan_n;
    logic [MAX_W-1:0] quiet_ext;
    logic [MAX_W-1:0] dnan_ext;

    fpnan_classify_lane #(.EXP_W(EW), .FRAC_W(FW)) i_cls (
      .mag_i     (in_operand[TW-2:0]),
      .pol_i     (snan_pol),
      .nosig_i   (nosig_mode),
      .is_nan_o  (lane_nan[g]),
      .is_qnan_o (lane_qnan[g]),
      .is_snan_o (lane_snan[g])
    );

    fpnan_pattern_lane #(.EXP_W(EW), .FRAC_W(FW)) i_pat (
      .op_i      (in_operand[TW-1:0]),
      .is_snan_i (lane_snan[g]),
      .pol_i     (snan_pol),
      .style_i   (dnan_style),
      .quiet_o   (quiet_n),
      .dnan_o    (dnan_n)
    );

    always_comb begin
      quiet_ext = '0;
      dnan_ext  = '0;
      quiet_ext[TW-1:0] = quiet_n;
      dnan_ext[TW-1:0]  = dnan_n;
    end
  end

  logic [MAX_W-1:0] sel_quiet;
  logic [MAX_W-1:0] sel_dnan;

  always_comb begin
    case (fp_fmt_e'(in_fmt))
      FMT_HALF:   begin sel_quiet = g_lane[0].quiet_ext; sel_dnan = g_lane[0].dnan_ext; end
      FMT_BF16:   begin sel_quiet = g_lane[1].quiet_ext; sel_dnan = g_lane[1].dnan_ext; end
      FMT_SINGLE: begin sel_quiet = g_lane[2].quiet_ext; sel_dnan = g_lane[2].dnan_ext; end
      default:    begin sel_quiet = g_lane[3].quiet_ext; sel_dnan = g_lane[3].dnan_ext; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_is_nan  <= 1'b0;
      out_is_qnan <= 1'b0;
      out_is_snan <= 1'b0;
      out_quiet   <= '0;
      out_dnan    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_is_nan  <= lane_nan[in_fmt];
        out_is_qnan <= lane_qnan[in_fmt];
        out_is_snan <= lane_snan[in_fmt];
        out_quiet   <= sel_quiet;
        out_dnan    <= sel_dnan;
      end
    end
  end

endmodule

// File: rtl/fpnan_unit_chk.sv
module fpnan_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        nosig_mode,
  input logic        out_valid,
  input logic        out_is_nan,
  input logic        out_is_qnan,
  input logic        out_is_snan,
  input logic [63:0] out_quiet,
  input logic [63:0] out_dnan
);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_quiet) && $stable(out_dnan) && $stable(out_is_nan)));

  p_nosig_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && nosig_mode) |=> !out_is_snan);

  p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_is_qnan, out_is_snan}));

  p_nan_split_r6: assert property (@(posedge clk) disable iff (rst)
    out_is_nan == (out_is_qnan || out_is_snan));

endmodule

bind fpnan_unit fpnan_unit_chk i_fpnan_unit_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .nosig_mode  (nosig_mode),
  .out_valid   (out_valid),
  .out_is_nan  (out_is_nan),
  .out_is_qnan (out_is_qnan),
  .out_is_snan (out_is_snan),
  .out_quiet   (out_quiet),
  .out_dnan    (out_dnan)
);

// File: tb/test_fpnan_unit.sv
`timescale 1ns/1ps
module test_fpnan_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  in_fmt;
  logic [63:0] in_operand;
  logic        snan_pol;
  logic        nosig_mode;
  logic [1:0]  dnan_style;
  logic        out_valid;
  logic        out_is_nan;
  logic        out_is_qnan;
  logic        out_is_snan;
  logic [63:0] out_quiet;
  logic [63:0] out_dnan;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fpnan_unit i_fpnan_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_operand(in_operand), .snan_pol(snan_pol), .nosig_mode(nosig_mode),
    .dnan_style(dnan_style), .out_valid(out_valid), .out_is_nan(out_is_nan),
    .out_is_qnan(out_is_qnan), .out_is_snan(out_is_snan),
    .out_quiet(out_quiet), .out_dnan(out_dnan)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Apply one strobe and compare the registered results one cycle later.
  task automatic run(input string tag, input logic [1:0] fmt, input logic [63:0] op,
                     input logic pol, input logic nosig, input logic [1:0] style,
                     input logic e_nan, input logic e_q, input logic e_s,
                     input logic [63:0] e_quiet, input logic [63:0] e_dnan);
    @(negedge clk);
    in_fmt = fmt; in_operand = op; snan_pol = pol; nosig_mode = nosig;
    dnan_style = style; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cmp(tag, "valid", {63'd0, out_valid}, 64'd1);
    cmp(tag, "is_nan", {63'd0, out_is_nan}, {63'd0, e_nan});
    cmp(tag, "is_qnan", {63'd0, out_is_qnan}, {63'd0, e_q});
    cmp(tag, "is_snan", {63'd0, out_is_snan}, {63'd0, e_s});
    cmp(tag, "quiet", out_quiet, e_quiet);
    cmp(tag, "dnan", out_dnan, e_dnan);
  endtask

  task automatic t_reset_r1;
    @(negedge clk);
    cmp("R1", "valid", {63'd0, out_valid}, 64'd0);
    cmp("R1", "flags", {61'd0, out_is_nan, out_is_qnan, out_is_snan}, 64'd0);
    cmp("R1", "quiet", out_quiet, 64'd0);
    cmp("R1", "dnan", out_dnan, 64'd0);
  endtask

  task automatic t_pol0_r3;
    run("R3", 2'd0, 64'h7E00, 0, 0, 0, 1, 1, 0, 64'h7E00, 64'h7E00);
    run("R3", 2'd0, 64'h7C01, 0, 0, 0, 1, 0, 1, 64'h7E01, 64'h7E00);
    run("R3", 2'd1, 64'h7FC0, 0, 0, 0, 1, 1, 0, 64'h7FC0, 64'h7FC0);
    run("R3", 2'd1, 64'h7F81, 0, 0, 0, 1, 0, 1, 64'h7FC1, 64'h7FC0);
    run("R3", 2'd2, 64'h7FC00000, 0, 0, 0, 1, 1, 0, 64'h7FC00000, 64'h7FC00000);
    run("R3", 2'd3, 64'h7FF0000000000001, 0, 0, 0, 1, 0, 1,
        64'h7FF8000000000001, 64'h7FF8000000000000);
    run("R3", 2'd3, 64'hFFF8000000000000, 0, 0, 0, 1, 1, 0,
        64'hFFF8000000000000, 64'h7FF8000000000000);
  endtask

  task automatic t_pol1_r4;
    run("R4", 2'd0, 64'h7E00, 1, 0, 0, 1, 0, 1, 64'h7D00, 64'h7DFF);
    run("R4", 2'd0, 64'h7C01, 1, 0, 0, 1, 1, 0, 64'h7C01, 64'h7DFF);
    run("R4", 2'd1, 64'h7F81, 1, 0, 0, 1, 1, 0, 64'h7F81, 64'h7FBF);
    run("R4", 2'd2, 64'h7FC00000, 1, 0, 0, 1, 0, 1, 64'h7FA00000, 64'h7FBFFFFF);
    run("R4", 2'd3, 64'h7FF0000000000001, 1, 0, 0, 1, 1, 0,
        64'h7FF0000000000001, 64'h7FF7FFFFFFFFFFFF);
  endtask

  task automatic t_nosig_r5;
    run("R5", 2'd2, 64'h7F800001, 0, 1, 0, 1, 1, 0, 64'h7F800001, 64'h7FC00000);
    run("R5", 2'd2, 64'h7FC00000, 1, 1, 0, 1, 1, 0, 64'h7FC00000, 64'h7FBFFFFF);
    run("R5", 2'd0, 64'h7E00, 1, 1, 0, 1, 1, 0, 64'h7E00, 64'h7DFF);
  endtask

  task automatic t_nonnan_r6;
    run("R6", 2'd2, 64'h7F800000, 0, 0, 0, 0, 0, 0, 64'h7F800000, 64'h7FC00000);
    run("R6", 2'd2, 64'h7F800000, 1, 0, 0, 0, 0, 0, 64'h7F800000, 64'h7FBFFFFF);
    run("R6", 2'd2, 64'h3F800000, 0, 0, 0, 0, 0, 0, 64'h3F800000, 64'h7FC00000);
    run("R6", 2'd3, 64'h8000000000000000, 0, 0, 0, 0, 0, 0,
        64'h8000000000000000, 64'h7FF8000000000000);
    run("R6", 2'd0, 64'hFC00, 0, 1, 0, 0, 0, 0, 64'hFC00, 64'h7E00);
  endtask

  task automatic t_quiet0_r7;
    run("R7", 2'd2, 64'hFF800005, 0, 0, 0, 1, 0, 1, 64'hFFC00005, 64'h7FC00000);
    run("R7", 2'd0, 64'hDEAD0000_00007C01, 0, 0, 0, 1, 0, 1, 64'h7E01, 64'h7E00);
    run("R7", 2'd1, 64'hFFFF_FFFF_FFFF_4049, 0, 0, 0, 0, 0, 0, 64'h4049, 64'h7FC0);
  endtask

  task automatic t_quiet1_r8;
    run("R8", 2'd0, 64'hFF05, 1, 0, 0, 1, 0, 1, 64'hFD05, 64'h7DFF);
    run("R8", 2'd3, 64'h7FF8000000000000, 1, 0, 0, 1, 0, 1,
        64'h7FF4000000000000, 64'h7FF7FFFFFFFFFFFF);
  endtask

  task automatic t_dnan_r9_r10_r11;
    run("R9",  2'd3, 64'd0, 0, 0, 3, 0, 0, 0, 64'd0, 64'h7FF8000000000000);
    run("R9",  2'd0, 64'd0, 1, 0, 3, 0, 0, 0, 64'd0, 64'h7DFF);
    run("R10", 2'd1, 64'd0, 0, 0, 1, 0, 0, 0, 64'd0, 64'h7FFF);
    run("R10", 2'd2, 64'd0, 1, 0, 1, 0, 0, 0, 64'd0, 64'h7FFFFFFF);
    run("R10", 2'd3, 64'd0, 0, 0, 1, 0, 0, 0, 64'd0, 64'h7FFFFFFFFFFFFFFF);
    run("R11", 2'd2, 64'd0, 1, 0, 2, 0, 0, 0, 64'd0, 64'hFFC00000);
    run("R11", 2'd0, 64'd0, 0, 0, 2, 0, 0, 0, 64'd0, 64'hFE00);
    run("R11", 2'd3, 64'd0, 1, 0, 2, 0, 0, 0, 64'd0, 64'hFFF8000000000000);
  endtask

  task automatic t_hold_r2;
    run("R2", 2'd2, 64'h7F800001, 0, 0, 0, 1, 0, 1, 64'h7FC00001, 64'h7FC00000);
    @(negedge clk);
    in_fmt = 2'd0; in_operand = 64'h7E00; snan_pol = 1'b1; dnan_style = 2'd1;
    @(negedge clk);
    cmp("R2", "valid idle", {63'd0, out_valid}, 64'd0);
    cmp("R2", "flags held", {61'd0, out_is_nan, out_is_qnan, out_is_snan}, 64'd5);
    cmp("R2", "quiet held", out_quiet, 64'h7FC00001);
    cmp("R2", "dnan held", out_dnan, 64'h7FC00000);
  endtask

  bit done = 0;

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_fmt = '0; in_operand = '0;
    snan_pol = 1'b0; nosig_mode = 1'b0; dnan_style = '0;
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst = 1'b0;
    t_reset_r1();
    t_pol0_r3();
    t_pol1_r4();
    t_nosig_r5();
    t_nonnan_r6();
    t_quiet0_r7();
    t_quiet1_r8();
    t_dnan_r9_r10_r11();
    t_hold_r2();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule